// File: doc/BRIEF.md
# Segmented Address and Branch Unit

This unit produces the addresses for a small 16-bit processor that splits its memory into 4-bit segments of 4096 words. An instruction address is the code segment register joined to a 12-bit program counter. A data address is the data segment register joined to a 12-bit offset that comes with the access. The unit moves the program counter one word at a time as fetches advance. It applies branches in two forms. A near branch replaces only the offset and keeps the current code segment. A far branch loads both the segment and the offset from a 16-bit target value.

The unit also holds a one-bit memory-space flag. This flag decides whether loads and stores go to data memory or to instruction memory. A toggle request, which the decoder raises when it sees the code segment register XORed with itself, flips the flag. The unit also holds a 4-bit I/O address register. The I/O port address comes either from that register or from an immediate field, as the mode input selects.

The program counter path is a small next-action selector. Each cycle it picks one of four actions. PC_HOLD keeps the counter. PC_STEP adds one to it. PC_NEAR loads the target's low 12 bits. PC_FAR loads the whole target into the segment and the counter. Branch actions take precedence over stepping. The selector is chosen again on every cycle and goes back to PC_HOLD whenever no request is present.

Top module: `seg_addr_unit`

## Requirements
- R1: After reset, the code segment, program counter, data segment, I/O address register and memory-space flag are all zero. So `instr_addr_o` reads 0x0000, `mem_space_o` reads 0, and with `io_sel_reg_i`=1 `io_port_o` reads 0.
- R2: A cycle with `fetch_adv_i`=1 and no branch raises the low 12 bits of `instr_addr_o` by one on the next cycle. The top 4 bits stay unchanged.
- R3: Stepping from offset 0xFFF wraps the offset to 0x000 inside the same segment. The segment bits do not carry.
- R4: A near branch (`br_valid_i`=1, `br_far_i`=0) sets the offset to `br_target_i[11:0]` and keeps the code segment.
- R5: A far branch (`br_valid_i`=1, `br_far_i`=1) makes `instr_addr_o` equal all 16 bits of `br_target_i` on the next cycle.
- R6: A branch in the same cycle as `fetch_adv_i` wins over the step. A far branch in the same cycle as `cs_we_i` wins over the segment write.
- R7: `cs_we_i` loads `wr_data_i[3:0]` into the code segment (bits 15:12 of `instr_addr_o`) and leaves the program counter unchanged.
- R8: While `data_req_i`=1, `data_addr_o` is {data segment, `data_off_i`}. While `data_req_i`=0 it reads zero. `ds_we_i` loads `wr_data_i[3:0]` into the data segment.
- R9: `space_tgl_i` complements `mem_space_o` on the next cycle. In `mem_space_o`, 0 selects data memory and 1 selects instruction memory for loads and stores.
- R10: `io_port_o` equals `io_imm_i` when `io_sel_reg_i`=0, and the I/O address register when it is 1. `ior_we_i` loads `wr_data_i[3:0]` into that register.
- R11: In a cycle with no request, all held state is unchanged: instruction address, data segment, I/O address register and memory-space flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_adv_i | input | 1 | Step the program counter by one |
| br_valid_i | input | 1 | Branch request |
| br_far_i | input | 1 | 1 = far branch, 0 = near branch |
| br_target_i | input | 16 | Branch target register value |
| data_req_i | input | 1 | Data access in progress |
| data_off_i | input | 12 | Data offset of the access |
| cs_we_i | input | 1 | Write code segment |
| ds_we_i | input | 1 | Write data segment |
| ior_we_i | input | 1 | Write I/O address register |
| wr_data_i | input | 16 | Source value for register writes (low 4 bits used) |
| space_tgl_i | input | 1 | Complement the memory-space flag |
| io_sel_reg_i | input | 1 | 1 = port from I/O register, 0 = immediate |
| io_imm_i | input | 4 | Immediate port number |
| instr_addr_o | output | 16 | Instruction fetch address |
| data_addr_o | output | 16 | Data access address |
| mem_space_o | output | 1 | 0 = data memory, 1 = instruction memory |
| io_port_o | output | 4 | I/O port address |

## Verification
A wrong program counter or code segment shows on `instr_addr_o` on the cycle right after the faulty update. The bench therefore checks the address after every step, wrap and branch, including when a branch and a step or a segment write arrive together. A corrupted data segment or I/O register shows only when an access or port select reads it. Each register write is therefore followed at once by a read through `data_addr_o` or `io_port_o`. A flag that flips on its own shows on `mem_space_o` within one cycle, so the bench checks it across toggles and idle cycles.

// File: rtl/seg_pkg.sv
package seg_pkg;

    typedef enum logic [1:0] {
        PC_HOLD,
        PC_STEP,
        PC_NEAR,
        PC_FAR
    } pc_act_e;

    typedef enum logic {
        SPACE_DATA  = 1'b0,
        SPACE_INSTR = 1'b1
    } mem_space_e;

endpackage

// File: rtl/seg_pc_unit.sv
module seg_pc_unit
    import seg_pkg::*;
#(
    parameter int SEG_W = 4,
    parameter int OFF_W = 12
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     adv_i,
    input  logic                     br_valid_i,
    input  logic                     br_far_i,
    input  logic [SEG_W+OFF_W-1:0]   br_target_i,
    input  logic                     cs_we_i,
    input  logic [SEG_W-1:0]         cs_wdata_i,
    output logic [SEG_W-1:0]         cs_o,
    output logic [OFF_W-1:0]         pc_o
);

    localparam int ADDR_W = SEG_W + OFF_W;
    localparam logic [OFF_W-1:0] ONE = {{(OFF_W-1){1'b0}}, 1'b1};
    localparam logic [OFF_W-1:0] TOP = {OFF_W{1'b1}};

    pc_act_e            act;
    logic [SEG_W-1:0]   cs_q;
    logic [OFF_W-1:0]   pc_q;

    // next-action selection: branches outrank stepping
    always_comb begin
        if (br_valid_i && br_far_i)
            act = PC_FAR;
        else if (br_valid_i)
            act = PC_NEAR;
        else if (adv_i)
            act = PC_STEP;
        else
            act = PC_HOLD;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_q <= '0;
            pc_q <= '0;
        end else begin
            unique case (act)
                PC_FAR: begin
                    cs_q <= br_target_i[ADDR_W-1:OFF_W];
                    pc_q <= br_target_i[OFF_W-1:0];
                end
                PC_NEAR: begin
                    pc_q <= br_target_i[OFF_W-1:0];
                    if (cs_we_i) cs_q <= cs_wdata_i;
                end
                PC_STEP: begin
                    pc_q <= pc_q + ONE;
                    if (cs_we_i) cs_q <= cs_wdata_i;
                end
                PC_HOLD: begin
                    if (cs_we_i) cs_q <= cs_wdata_i;
                end
                default: begin
                    pc_q <= pc_q;
                end
            endcase
        end
    end

    assign cs_o = cs_q;
    assign pc_o = pc_q;

    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && !br_valid_i && !cs_we_i) |=> (pc_q == $past(pc_q) + ONE) && (cs_q == $past(cs_q)));

    p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && !br_valid_i && pc_q == TOP) |=> (pc_q == '0));

    p_near_keeps_seg_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (br_valid_i && !br_far_i && !cs_we_i) |=> $stable(cs_q));

    p_far_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (br_valid_i && br_far_i) |=> ({cs_q, pc_q} == $past(br_target_i)));

    p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv_i && !br_valid_i && !cs_we_i) |=> ($stable(pc_q) && $stable(cs_q)));

endmodule

// File: rtl/seg_cfg_regs.sv
module seg_cfg_regs
    import seg_pkg::*;
#(
    parameter int SEG_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ds_we_i,
    input  logic               ior_we_i,
    input  logic [SEG_W-1:0]   wdata_i,
    input  logic               tgl_i,
    output logic [SEG_W-1:0]   ds_o,
    output logic [SEG_W-1:0]   ior_o,
    output mem_space_e         space_o
);

    logic [SEG_W-1:0] ds_q;
    logic [SEG_W-1:0] ior_q;
    mem_space_e       space_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ds_q    <= '0;
            ior_q   <= '0;
            space_q <= SPACE_DATA;
        end else begin
            if (ds_we_i)  ds_q  <= wdata_i;
            if (ior_we_i) ior_q <= wdata_i;
            if (tgl_i)
                space_q <= (space_q == SPACE_DATA) ? SPACE_INSTR : SPACE_DATA;
        end
    end

    assign ds_o    = ds_q;
    assign ior_o   = ior_q;
    assign space_o = space_q;

    p_toggle_flip_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tgl_i |=> (space_q != $past(space_q)));

    p_flag_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !tgl_i |=> $stable(space_q));

    p_regs_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!ds_we_i && !ior_we_i) |=> ($stable(ds_q) && $stable(ior_q)));

endmodule

// File: rtl/seg_addr_unit.sv
module seg_addr_unit
    import seg_pkg::*;
#(
    parameter int SEG_W = 4,
    parameter int OFF_W = 12
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     fetch_adv_i,
    input  logic                     br_valid_i,
    input  logic                     br_far_i,
    input  logic [SEG_W+OFF_W-1:0]   br_target_i,
    input  logic                     data_req_i,
    input  logic [OFF_W-1:0]         data_off_i,
    input  logic                     cs_we_i,
    input  logic                     ds_we_i,
    input  logic                     ior_we_i,
    input  logic [SEG_W+OFF_W-1:0]   wr_data_i,
    input  logic                     space_tgl_i,
    input  logic                     io_sel_reg_i,
    input  logic [SEG_W-1:0]         io_imm_i,
    output logic [SEG_W+OFF_W-1:0]   instr_addr_o,
    output logic [SEG_W+OFF_W-1:0]   data_addr_o,
    output logic                     mem_space_o,
    output logic [SEG_W-1:0]         io_port_o
);

    localparam int ADDR_W = SEG_W + OFF_W;

    logic [SEG_W-1:0] cs, ds, ior;
    logic [OFF_W-1:0] pc;
    mem_space_e       space;
    logic [SEG_W-1:0] wr_low;

    assign wr_low = wr_data_i[SEG_W-1:0];

    seg_pc_unit #(.SEG_W(SEG_W), .OFF_W(OFF_W)) u_pc (
        .clk         (clk),
        .rst_n       (rst_n),
        .adv_i       (fetch_adv_i),
        .br_valid_i  (br_valid_i),
        .br_far_i    (br_far_i),
        .br_target_i (br_target_i),
        .cs_we_i     (cs_we_i),
        .cs_wdata_i  (wr_low),
        .cs_o        (cs),
        .pc_o        (pc)
    );

    seg_cfg_regs #(.SEG_W(SEG_W)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .ds_we_i  (ds_we_i),
        .ior_we_i (ior_we_i),
        .wdata_i  (wr_low),
        .tgl_i    (space_tgl_i),
        .ds_o     (ds),
        .ior_o    (ior),
        .space_o  (space)
    );

    assign instr_addr_o = {cs, pc};
    assign data_addr_o  = data_req_i ? {ds, data_off_i} : {ADDR_W{1'b0}};
    assign mem_space_o  = (space == SPACE_INSTR);
    assign io_port_o    = io_sel_reg_i ? ior : io_imm_i;

    p_far_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (br_valid_i && br_far_i && cs_we_i) |=> (instr_addr_o == $past(br_target_i)));

    p_near_offset_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (br_valid_i && !br_far_i) |=> (instr_addr_o[OFF_W-1:0] == $past(br_target_i[OFF_W-1:0])));

endmodule

// File: tb/seg_addr_unit_bench.sv
`timescale 1ns/1ps
module seg_addr_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fetch_adv_i = 0, br_valid_i = 0, br_far_i = 0;
    logic [15:0] br_target_i = '0;
    logic        data_req_i = 0;
    logic [11:0] data_off_i = '0;
    logic        cs_we_i = 0, ds_we_i = 0, ior_we_i = 0;
    logic [15:0] wr_data_i = '0;
    logic        space_tgl_i = 0, io_sel_reg_i = 0;
    logic [3:0]  io_imm_i = '0;
    logic [15:0] instr_addr_o, data_addr_o;
    logic        mem_space_o;
    logic [3:0]  io_port_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    seg_addr_unit u_seg_addr_unit (
        .clk(clk), .rst_n(rst_n), .fetch_adv_i(fetch_adv_i), .br_valid_i(br_valid_i),
        .br_far_i(br_far_i), .br_target_i(br_target_i), .data_req_i(data_req_i),
        .data_off_i(data_off_i), .cs_we_i(cs_we_i), .ds_we_i(ds_we_i), .ior_we_i(ior_we_i),
        .wr_data_i(wr_data_i), .space_tgl_i(space_tgl_i), .io_sel_reg_i(io_sel_reg_i),
        .io_imm_i(io_imm_i), .instr_addr_o(instr_addr_o), .data_addr_o(data_addr_o),
        .mem_space_o(mem_space_o), .io_port_o(io_port_o)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
        end
    endtask

    task automatic clear_pulses();
        fetch_adv_i = 0; br_valid_i = 0; br_far_i = 0;
        cs_we_i = 0; ds_we_i = 0; ior_we_i = 0; space_tgl_i = 0;
    endtask

    // pulses set before the call are captured at the next edge, then dropped
    task automatic tick();
        @(negedge clk);
        clear_pulses();
    endtask

    task automatic t_reset();
        io_sel_reg_i = 1; data_req_i = 1; data_off_i = '0;
        #1;
        check("R1 instr", instr_addr_o, 16'h0000);
        check("R1 space", {15'd0, mem_space_o}, 16'h0000);
        check("R1 io", {12'd0, io_port_o}, 16'h0000);
        check("R1 data", data_addr_o, 16'h0000);
        data_req_i = 0;
    endtask

    task automatic t_step();
        for (int i = 0; i < 3; i++) begin
            fetch_adv_i = 1; tick();
        end
        check("R2 step", instr_addr_o, 16'h0003);
    endtask

    task automatic t_cs_write();
        cs_we_i = 1; wr_data_i = 16'hABC5; tick();
        check("R7 cs write", instr_addr_o, 16'h5003);
    endtask

    task automatic t_near();
        br_valid_i = 1; br_target_i = 16'h9123; tick();
        check("R4 near", instr_addr_o, 16'h5123);
    endtask

    task automatic t_wrap();
        br_valid_i = 1; br_target_i = 16'h0FFF; tick();
        check("R4 near top", instr_addr_o, 16'h5FFF);
        fetch_adv_i = 1; tick();
        check("R3 wrap", instr_addr_o, 16'h5000);
    endtask

    task automatic t_far();
        br_valid_i = 1; br_far_i = 1; br_target_i = 16'hC7A0; tick();
        check("R5 far", instr_addr_o, 16'hC7A0);
        fetch_adv_i = 1; tick();
        check("R2 after far", instr_addr_o, 16'hC7A1);
    endtask

    task automatic t_priority();
        br_valid_i = 1; br_far_i = 1; br_target_i = 16'h1234;
        fetch_adv_i = 1; cs_we_i = 1; wr_data_i = 16'h000F; tick();
        check("R6 far over step and cs", instr_addr_o, 16'h1234);
        br_valid_i = 1; br_target_i = 16'h0055; fetch_adv_i = 1; tick();
        check("R6 near over step", instr_addr_o, 16'h1055);
    endtask

    task automatic t_data();
        ds_we_i = 1; wr_data_i = 16'hFFF9; tick();
        data_req_i = 1; data_off_i = 12'h3AB; #1;
        check("R8 data addr", data_addr_o, 16'h93AB);
        check("R8 instr untouched", instr_addr_o, 16'h1055);
        data_req_i = 0; #1;
        check("R8 idle data zero", data_addr_o, 16'h0000);
    endtask

    task automatic t_space();
        space_tgl_i = 1; tick();
        check("R9 toggle to instr", {15'd0, mem_space_o}, 16'h0001);
        tick();
        check("R11 flag held", {15'd0, mem_space_o}, 16'h0001);
        space_tgl_i = 1; tick();
        check("R9 toggle back", {15'd0, mem_space_o}, 16'h0000);
    endtask

    task automatic t_io();
        ior_we_i = 1; wr_data_i = 16'h123E; tick();
        io_sel_reg_i = 1; #1;
        check("R10 io reg", {12'd0, io_port_o}, 16'h000E);
        io_sel_reg_i = 0; io_imm_i = 4'h6; #1;
        check("R10 io imm", {12'd0, io_port_o}, 16'h0006);
    endtask

    task automatic t_idle();
        wr_data_i = 16'hFFFF; br_target_i = 16'hFFFF;
        for (int i = 0; i < 4; i++) tick();
        check("R11 instr held", instr_addr_o, 16'h1055);
        io_sel_reg_i = 1; data_req_i = 1; data_off_i = 12'h001; #1;
        check("R11 ior held", {12'd0, io_port_o}, 16'h000E);
        check("R11 ds held", data_addr_o, 16'h9001);
        data_req_i = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_step();
        t_cs_write();
        t_near();
        t_wrap();
        t_far();
        t_priority();
        t_data();
        t_space();
        t_io();
        t_idle();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        #50000;
        if (!finished) begin
            finished = 1;
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule